// File: doc/BRIEF.md
# SDRAM Idle Self-Refresh Manager

This block watches SDRAM traffic and puts the memory into its low-power self-refresh state once the bus has been quiet for a programmable number of clock cycles. An idle counter runs while self-refresh is enabled. Every access request and every auto-refresh command issued elsewhere restarts it. When the counter reaches the programmed limit, the block takes over the command pins. It issues a precharge-all command, waits out the row-precharge time, then issues the self-refresh command and drops the clock-enable pin at the same time. It can also stop the SDRAM clock while the memory refreshes itself.

A new access request, or clearing the enable control, wakes the memory. The clock is restarted first, and clock-enable is raised one cycle later. The block then inserts the exit-recovery time as NOP cycles and hands the bus back to the main access sequencer through a busy/go handshake. The idle count then starts again from zero. A status output shows when the memory is held in self-refresh.

Top module: `sdr_selfref_mgr`

## Requirements
- R1: While `cfg_en` is 0, the idle counter is held at zero and no entry sequence ever starts. `cfg_idle_cnt` must lie in 1..127 while `cfg_en` is 1.
- R2: With `cfg_idle_cnt` = N, precharge-all appears on the pins exactly N cycles after the last cycle in which activity or a disabled enable was sampled.
- R3: Any cycle with `acc_req` or `arf_issued` high, sampled while not in self-refresh, restarts the idle count from zero.
- R4: Pin encodings are as follows. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0. Precharge-all is cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. Self-refresh is cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0.
- R5: Self-refresh is issued T_RP cycles after precharge-all, with NOPs in between. CKE falls in the same cycle as the self-refresh command.
- R6: CKE stays low until an exit trigger, which is `acc_req` high or `cfg_en` low, sampled during self-refresh. On exit, `sdclk_en` is high one cycle before CKE rises, and the cycle in which CKE rises carries a NOP.
- R7: After CKE rises, exactly T_XSR NOP cycles pass before `sr_busy` drops. Self-refresh is re-entered only after the idle count again reaches N.
- R8: `sr_status` is 1 exactly while CKE is held low.
- R9: `sdclk_en` is 0 only in self-refresh cycles after the one carrying the self-refresh command, and only while `cfg_clk_keep` was 0 at the previous edge. It is 1 at all other times.
- R10: `sr_busy` is high from the precharge-all cycle through the last recovery cycle. `acc_go` equals `acc_req` and not `sr_busy`.
- R11: A request that arrives during the precharge wait does not abort entry. The self-refresh command is still issued, and exit begins on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Automatic self-refresh enable |
| cfg_idle_cnt | input | CNT_W | Idle cycles before entry (1..127) |
| cfg_clk_keep | input | 1 | 1 keeps the SDRAM clock running in self-refresh |
| acc_req | input | 1 | Access pending from the main sequencer (level, held until go) |
| arf_issued | input | 1 | Auto-refresh command issued this cycle |
| sdr_cs_n | output | 1 | Chip select |
| sdr_ras_n | output | 1 | Row strobe |
| sdr_cas_n | output | 1 | Column strobe |
| sdr_we_n | output | 1 | Write enable |
| sdr_a10 | output | 1 | Address bit 10 (all-banks select) |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdclk_en | output | 1 | Enable for the SDRAM clock gate |
| sr_busy | output | 1 | Block owns the command pins |
| acc_go | output | 1 | Pending access may proceed this cycle |
| sr_status | output | 1 | Self-refresh in progress |

## Verification
A corrupted idle count shows at the pins as a precharge-all that comes one or more cycles early or late, or that never comes. The bench sees this in the first cycle it should have appeared. A wrong sequencer state shows within one cycle as a mismatch on CKE, on the status bit, on the clock gate or on the command encoding. A bad wait counter shifts the self-refresh command or the return of `sr_busy` to low by whole cycles. A cycle-accurate reference model checks every output in every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/sdr_selfref_pkg.sv
package sdr_selfref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SR,
        ST_WAKE,
        ST_XSR
    } sr_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PALL,
        CMD_SELF
    } sr_cmd_e;

endpackage

// File: rtl/sr_idle_cnt.sv
module sr_idle_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        hit   = run && !clr && (nxt == {1'b0, limit});
        cnt_d = cnt_q;
        if (clr || hit) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = nxt[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sr_cmd_enc.sv
module sr_cmd_enc
    import sdr_selfref_pkg::*;
(
    input  sr_cmd_e cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n,
    output logic    a10
);
    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        a10   = 1'b0;
        unique case (cmd)
            CMD_PALL: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                a10   = 1'b1;
            end
            CMD_SELF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdr_selfref_mgr.sv
module sdr_selfref_mgr
    import sdr_selfref_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int T_RP  = 2,
    parameter int T_XSR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [CNT_W-1:0] cfg_idle_cnt,
    input  logic             cfg_clk_keep,
    input  logic             acc_req,
    input  logic             arf_issued,
    output logic             sdr_cs_n,
    output logic             sdr_ras_n,
    output logic             sdr_cas_n,
    output logic             sdr_we_n,
    output logic             sdr_a10,
    output logic             sdr_cke,
    output logic             sdclk_en,
    output logic             sr_busy,
    output logic             acc_go,
    output logic             sr_status
);
    localparam int WT_MAX = (T_RP > T_XSR) ? T_RP : T_XSR;
    localparam int WT_W   = (WT_MAX < 2) ? 1 : $clog2(WT_MAX);
    localparam logic [WT_W-1:0] RP_LAST  = WT_W'(T_RP - 1);
    localparam logic [WT_W-1:0] XSR_LAST = WT_W'(T_XSR - 1);

    typedef struct packed {
        sr_state_e       st;
        logic [WT_W-1:0] wt;
        logic            cke;
        logic            stat;
        logic            clk_on;
        sr_cmd_e         cmd;
    } sr_regs_t;

    sr_regs_t r_d, r_q;
    logic     idle_clr;
    logic     idle_run;
    logic     idle_hit;

    assign idle_run = (r_q.st == ST_IDLE);
    assign idle_clr = !cfg_en || acc_req || arf_issued;

    sr_idle_cnt #(.W(CNT_W)) u_idle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .run   (idle_run),
        .limit (cfg_idle_cnt),
        .hit   (idle_hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.cmd = CMD_NOP;
        unique case (r_q.st)
            ST_IDLE: begin
                if (idle_hit) begin
                    r_d.st  = ST_PRE;
                    r_d.cmd = CMD_PALL;
                    r_d.wt  = '0;
                end
            end
            ST_PRE: begin
                if (r_q.wt == RP_LAST) begin
                    r_d.st   = ST_SR;
                    r_d.cmd  = CMD_SELF;
                    r_d.cke  = 1'b0;
                    r_d.stat = 1'b1;
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            ST_SR: begin
                r_d.clk_on = cfg_clk_keep;
                if (acc_req || !cfg_en) begin
                    r_d.st     = ST_WAKE;
                    r_d.clk_on = 1'b1;
                end
            end
            ST_WAKE: begin
                r_d.st   = ST_XSR;
                r_d.cke  = 1'b1;
                r_d.stat = 1'b0;
                r_d.wt   = '0;
            end
            ST_XSR: begin
                if (r_q.wt == XSR_LAST) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.wt     <= '0;
            r_q.cke    <= 1'b1;
            r_q.stat   <= 1'b0;
            r_q.clk_on <= 1'b1;
            r_q.cmd    <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    sr_cmd_enc u_cmd_enc (
        .cmd   (r_q.cmd),
        .cs_n  (sdr_cs_n),
        .ras_n (sdr_ras_n),
        .cas_n (sdr_cas_n),
        .we_n  (sdr_we_n),
        .a10   (sdr_a10)
    );

    assign sdr_cke   = r_q.cke;
    assign sr_status = r_q.stat;
    assign sdclk_en  = r_q.clk_on;
    assign sr_busy   = (r_q.st != ST_IDLE);
    assign acc_go    = acc_req && (r_q.st == ST_IDLE);
endmodule

// File: rtl/sdr_selfref_chk.sv
module sdr_selfref_chk (
    input logic clk,
    input logic rst_n,
    input logic sdr_cs_n,
    input logic sdr_ras_n,
    input logic sdr_cas_n,
    input logic sdr_we_n,
    input logic sdr_a10,
    input logic sdr_cke,
    input logic sdclk_en,
    input logic sr_busy,
    input logic acc_go,
    input logic sr_status
);
    logic pin_self;
    logic pin_nop;
    assign pin_self = !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n && !sdr_a10;
    assign pin_nop  = !sdr_cs_n && sdr_ras_n && sdr_cas_n && sdr_we_n && !sdr_a10;

    a_r5_self_on_cke_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke) |-> pin_self);

    a_r8_status_tracks_cke: assert property (@(posedge clk) disable iff (!rst_n)
        sr_status == !sdr_cke);

    a_r9_clock_stop_only_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        !sdclk_en |-> (!sdr_cke && sr_busy));

    a_r6_clock_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke) |-> ($past(sdclk_en) && pin_nop));

    a_r10_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> (!sr_busy && sdr_cke));

    a_r10_free_means_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_busy |-> (sdr_cke && pin_nop));
endmodule

bind sdr_selfref_mgr sdr_selfref_chk u_sdr_selfref_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdr_cs_n  (sdr_cs_n),
    .sdr_ras_n (sdr_ras_n),
    .sdr_cas_n (sdr_cas_n),
    .sdr_we_n  (sdr_we_n),
    .sdr_a10   (sdr_a10),
    .sdr_cke   (sdr_cke),
    .sdclk_en  (sdclk_en),
    .sr_busy   (sr_busy),
    .acc_go    (acc_go),
    .sr_status (sr_status)
);

// File: tb/sdr_selfref_mgr_bench.sv
module sdr_selfref_mgr_bench;
    localparam int TRP  = 3;
    localparam int TXSR = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [6:0] cfg_idle_cnt = 7'd4;
    logic       cfg_clk_keep = 1'b0;
    logic       acc_req = 1'b0;
    logic       arf_issued = 1'b0;
    logic       sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_a10;
    logic       sdr_cke, sdclk_en, sr_busy, acc_go, sr_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model: 0 idle, 1 precharge wait, 2 self-refresh, 3 wake, 4 recovery
    int m_st = 0, m_cnt = 0, m_wt = 0, m_cmd = 0;
    bit m_cke = 1'b1, m_stat = 1'b0, m_clk = 1'b1;

    always #5 clk = ~clk;

    sdr_selfref_mgr #(.CNT_W(7), .T_RP(TRP), .T_XSR(TXSR)) u_sdr_selfref_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_idle_cnt(cfg_idle_cnt),
        .cfg_clk_keep(cfg_clk_keep), .acc_req(acc_req), .arf_issued(arf_issued),
        .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
        .sdr_we_n(sdr_we_n), .sdr_a10(sdr_a10), .sdr_cke(sdr_cke),
        .sdclk_en(sdclk_en), .sr_busy(sr_busy), .acc_go(acc_go), .sr_status(sr_status)
    );

    function automatic logic [4:0] pins_of(int c);
        // {cs_n, ras_n, cas_n, we_n, a10}
        if (c == 1) return 5'b00101;
        if (c == 2) return 5'b00010;
        return 5'b01110;
    endfunction

    function automatic bit exp_go();
        return acc_req && (m_st == 0);
    endfunction

    task automatic model_step();
        int c = 0;
        case (m_st)
            0: begin
                if (!cfg_en || acc_req || arf_issued) m_cnt = 0;
                else if (m_cnt + 1 == int'(cfg_idle_cnt)) begin
                    m_cnt = 0; m_st = 1; m_wt = 0; c = 1;
                end else m_cnt++;
            end
            1: begin
                if (m_wt == TRP - 1) begin
                    m_st = 2; c = 2; m_cke = 1'b0; m_stat = 1'b1;
                end else m_wt++;
            end
            2: begin
                m_clk = cfg_clk_keep;
                if (acc_req || !cfg_en) begin m_st = 3; m_clk = 1'b1; end
            end
            3: begin m_st = 4; m_cke = 1'b1; m_stat = 1'b0; m_wt = 0; end
            default: begin
                if (m_wt == TXSR - 1) begin m_st = 0; m_cnt = 0; end
                else m_wt++;
            end
        endcase
        m_cmd = c;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cycles, act, exp);
        end
    endtask

    task automatic compare();
        logic [4:0] p = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_a10};
        chk(p == pins_of(m_cmd), (m_cmd == 1) ? "R2" : "R4", "command pins", p, pins_of(m_cmd));
        chk(sdr_cke == m_cke, "R5", "cke", sdr_cke, m_cke);
        chk(sr_status == m_stat, "R8", "status", sr_status, m_stat);
        chk(sdclk_en == m_clk, "R9", "clock enable", sdclk_en, m_clk);
        chk(sr_busy == (m_st != 0), "R7", "busy", sr_busy, m_st != 0);
        chk(acc_go == exp_go(), "R10", "go", acc_go, exp_go());
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_for(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_state(int s, int limit);
        for (int i = 0; i < limit && m_st != s; i++) tick();
    endtask

    task automatic serve_request(int hold);
        acc_req = 1'b1;
        for (int i = 0; i < 400 && !exp_go(); i++) tick();
        tick();
        for (int i = 0; i < hold; i++) tick();
        acc_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // reset state: NOP, cke high, clock running, not busy
        compare();
        chk(sdr_cke && !sr_status && sdclk_en && !sr_busy, "R8", "reset state",
            {sdr_cke, sr_status, sdclk_en, sr_busy}, 4'b1010);
        rst_n = 1'b1;

        // R1: disabled block never enters
        cfg_en = 1'b0; cfg_idle_cnt = 7'd3;
        idle_for(20);
        chk(m_st == 0 && sdr_cke, "R1", "no entry while disabled", sdr_cke, 1);

        // R2/R5: smallest count, clock stopped
        cfg_en = 1'b1; cfg_idle_cnt = 7'd1; cfg_clk_keep = 1'b0;
        wait_state(2, 50);
        idle_for(4);
        chk(!sdclk_en, "R9", "clock stopped in self-refresh", sdclk_en, 0);
        serve_request(2);

        // R3: auto-refresh strobes keep restarting the count
        cfg_idle_cnt = 7'd6;
        for (int i = 0; i < 5; i++) begin
            idle_for(4);
            arf_issued = 1'b1; tick(); arf_issued = 1'b0;
        end
        chk(m_st == 0 && !sr_busy, "R3", "auto-refresh restarts count", sr_busy, 0);

        // R6: disable during self-refresh exits without a request
        cfg_clk_keep = 1'b1;
        wait_state(2, 60);
        idle_for(3);
        chk(sdclk_en, "R9", "clock kept in self-refresh", sdclk_en, 1);
        cfg_en = 1'b0;
        wait_state(0, 40);
        chk(sdr_cke && !sr_busy, "R6", "exit on disable", sdr_cke, 1);
        idle_for(10);

        // R11: request during precharge wait
        cfg_en = 1'b1; cfg_idle_cnt = 7'd4;
        wait_state(1, 40);
        acc_req = 1'b1;
        tick();
        chk(sr_busy, "R11", "entry not aborted", sr_busy, 1);
        serve_request(1);

        // R2: largest count
        cfg_idle_cnt = 7'd127;
        idle_for(126);
        chk(!sr_busy, "R2", "no entry before 127 idle cycles", sr_busy, 0);
        tick();
        chk(sr_busy, "R2", "entry at 127 idle cycles", sr_busy, 1);
        serve_request(0);

        // constrained random episodes
        for (int ep = 0; ep < 300; ep++) begin
            int gap;
            cfg_idle_cnt = 7'(1 + $urandom % 24);
            cfg_clk_keep = $urandom % 2;
            gap = $urandom % (2 * int'(cfg_idle_cnt) + 2 * TRP + 8);
            for (int i = 0; i < gap; i++) begin
                arf_issued = ($urandom % 25 == 0);
                if ($urandom % 120 == 0) cfg_en = ~cfg_en;
                tick();
            end
            arf_issued = 1'b0;
            cfg_en = 1'b1;
            serve_request($urandom % 3);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule